// File: doc/BRIEF.md
# Prescaled Down-Counting Timer Channel

This block is one programmable timer channel. Software loads a start value into a reload register and then turns counting on through a control word. Counting can be one-shot or periodic. A free-running reference enable (`tick_en`) is divided by an 8-bit prescale setting plus one, and each divided step lowers the count by one. When the count runs out, the channel sets a sticky pending flag. In periodic mode it then reloads and keeps running. In one-shot mode it stops and turns its enable off.

The interrupt output is the pending flag gated by an interrupt-enable bit. Software clears the flag by writing a one to the pending-clear location. Several registers sit behind one narrow write/read port, selected by `wr_sel` and `rd_sel`: 0 is the control word, 1 is the reload value, 2 is the current count (read-only), and 3 is the pending flag in bit 0. Reads are combinational from the stored state. A write takes effect at the next rising clock edge.

Top module: `tmr_channel`

## Requirements
- R1: While reset is held low, the control word reads 0x00000005 (prescale 5, everything else clear). The reload value, the count, the pending flag and `irq` all read 0.
- R2: A control write (`wr_sel`=0) stores the following bits of `wr_data`: bit 30 as counter enable, bit 29 as interrupt enable, bit 27 as periodic mode and bits 7:0 as prescale. Bits 31, 28, 26 and 24:8 always read back as 0. The value written to bit 25 is ignored.
- R3: Control bit 25 is a read-only active flag. It is set when the enable goes from 0 to 1. It clears when the enable goes from 1 to 0 or when a one-shot run expires, so it always equals the enable.
- R4: While enabled, the count drops by one on every (prescale+1)-th cycle with `tick_en` high. Any control or reload write restarts this division phase at zero, and no step happens in the cycle of such a write.
- R5: A step taken while the count is 1 or 0 is a zero event, and a zero event sets the pending flag. In periodic mode the count reloads from the reload value and counting continues. In one-shot mode the count stays 0 and the enable and active bits clear.
- R6: A control write with bit 26 set copies the reload value into the count and forces the enable to 0 for that write, even if bit 30 is also set. Bit 26 reads back as 0.
- R7: A control write that turns the enable off holds the count. If the count left by that write is 0, a zero event is processed, using the periodic bit just written.
- R8: A reload write (`wr_sel`=1) sets both the reload value and the count to `wr_data`. The enable is not changed.
- R9: A write to the pending-clear location (`wr_sel`=3) with bit 0 set clears the pending flag. Bit 0 clear has no effect. A zero event in the same cycle wins, and the flag stays set.
- R10: `irq` is high exactly when both the interrupt enable and the pending flag are set.
- R11: A write to the count location (`wr_sel`=2) changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Reference enable, divided by prescale+1 |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 reload, 2 count, 3 pending-clear |
| wr_data | input | 32 | Write value |
| rd_sel | input | 2 | Read source, same encoding as `wr_sel` |
| rd_data | output | 32 | Read value of the selected location |
| irq | output | 1 | Interrupt request |

## Verification
Some properties are checked on every cycle:
- the active flag equals the enable;
- a counter-reset write leaves the enable off and the count at the previous reload value;
- an idle, disabled channel and writes to the count location never move the count;
- a clear write on a stopped channel drops the pending flag;
- a one-shot run leaves the count 0 with the flag set when it stops on its own.

The bench scenarios cover the rest against a cycle model:
- the division rate at several prescale settings;
- periodic reload;
- the zero event raised when disabling at a count of 0;
- a prescale change in the middle of a count;
- a set and a clear of the pending flag in the same cycle.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int unsigned BIT_EN  = 30;
  localparam int unsigned BIT_IE  = 29;
  localparam int unsigned BIT_PER = 27;
  localparam int unsigned BIT_RST = 26;
  localparam int unsigned BIT_ACT = 25;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_PEND   = 2'd3
  } tmr_sel_e;
endpackage

// File: rtl/tmr_ctrl.sv
`timescale 1ns/1ps
module tmr_ctrl #(
  parameter int unsigned PSC_W   = 8,
  parameter int unsigned RST_PSC = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             f_en,
  input  logic             f_ie,
  input  logic             f_per,
  input  logic             f_rst,
  input  logic [PSC_W-1:0] f_psc,
  input  logic             oneshot_done,
  output logic             en_q,
  output logic             ie_q,
  output logic             per_q,
  output logic             act_q,
  output logic [PSC_W-1:0] psc_q,
  output logic             per_eff,
  output logic             crst,
  output logic             en_fall
);
  logic             en_d, ie_d, per_d, act_d;
  logic [PSC_W-1:0] psc_d;
  logic             en_new;

  // restart and enable in one write: restart wins, enable dropped
  assign en_new  = f_en & ~f_rst;
  assign crst    = wr_ctrl & f_rst;
  assign en_fall = wr_ctrl & en_q & ~en_new;
  assign per_eff = wr_ctrl ? f_per : per_q;

  always_comb begin
    en_d  = en_q;
    ie_d  = ie_q;
    per_d = per_q;
    act_d = act_q;
    psc_d = psc_q;
    if (wr_ctrl) begin
      en_d  = en_new;
      ie_d  = f_ie;
      per_d = f_per;
      psc_d = f_psc;
      if (en_new && !en_q) begin
        act_d = 1'b1;
      end else if (!en_new && en_q) begin
        act_d = 1'b0;
      end
    end else if (oneshot_done) begin
      en_d  = 1'b0;
      act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ie_q  <= 1'b0;
      per_q <= 1'b0;
      act_q <= 1'b0;
      psc_q <= PSC_W'(RST_PSC);
    end else begin
      en_q  <= en_d;
      ie_q  <= ie_d;
      per_q <= per_d;
      act_q <= act_d;
      psc_q <= psc_d;
    end
  end
endmodule

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale #(
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick_en,
  input  logic             restart,
  input  logic [PSC_W-1:0] psc,
  output logic             step
);
  logic [PSC_W-1:0] ph_q, ph_d;
  logic             at_top, adv;

  assign at_top = (ph_q == psc);
  assign adv    = run & tick_en;
  assign step   = adv & at_top & ~restart;

  always_comb begin
    ph_d = ph_q;
    if (restart) begin
      ph_d = '0;
    end else if (adv) begin
      ph_d = at_top ? '0 : ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_d;
    end
  end
endmodule

// File: rtl/tmr_count.sv
`timescale 1ns/1ps
module tmr_count #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              wr_reload,
  input  logic              crst,
  input  logic              en_fall,
  input  logic              per_eff,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] count_q,
  output logic [DATA_W-1:0] reload_q,
  output logic              zero_evt,
  output logic              step_zero
);
  logic [DATA_W-1:0] count_d, reload_d, left;
  logic              dis_zero;

  assign step_zero = step & (count_q <= DATA_W'(1));
  assign left      = crst ? reload_q : count_q;
  assign dis_zero  = en_fall & (left == '0);
  assign zero_evt  = step_zero | dis_zero;

  always_comb begin
    reload_d = wr_reload ? wr_data : reload_q;
    count_d  = count_q;
    if (crst) begin
      count_d = reload_q;
    end else if (wr_reload) begin
      count_d = wr_data;
    end else if (zero_evt) begin
      count_d = per_eff ? reload_q : '0;
    end else if (step) begin
      count_d = count_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      reload_q <= '0;
    end else begin
      count_q  <= count_d;
      reload_q <= reload_d;
    end
  end
endmodule

// File: rtl/tmr_pend.sv
`timescale 1ns/1ps
module tmr_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  input  logic ie,
  output logic pend_q,
  output logic irq
);
  logic pend_d;

  always_comb begin
    pend_d = pend_q;
    if (set_evt) begin
      pend_d = 1'b1;
    end else if (clr_req) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign irq = ie & pend_q;
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PSC_W   = 8,
  parameter int unsigned RST_PSC = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  import tmr_pkg::*;

  logic              wr_ctrl, wr_reload, wr_pend;
  logic              en_q, ie_q, per_q, act_q, per_eff, crst, en_fall;
  logic [PSC_W-1:0]  psc_q;
  logic              step, zero_evt, step_zero;
  logic [DATA_W-1:0] count_q, reload_q, ctrl_word;
  logic              pend_q;

  assign wr_ctrl   = wr_en & (wr_sel == SEL_CTRL);
  assign wr_reload = wr_en & (wr_sel == SEL_RELOAD);
  assign wr_pend   = wr_en & (wr_sel == SEL_PEND);

  tmr_ctrl #(.PSC_W(PSC_W), .RST_PSC(RST_PSC)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_ctrl      (wr_ctrl),
    .f_en         (wr_data[BIT_EN]),
    .f_ie         (wr_data[BIT_IE]),
    .f_per        (wr_data[BIT_PER]),
    .f_rst        (wr_data[BIT_RST]),
    .f_psc        (wr_data[PSC_W-1:0]),
    .oneshot_done (step_zero & ~per_q),
    .en_q         (en_q),
    .ie_q         (ie_q),
    .per_q        (per_q),
    .act_q        (act_q),
    .psc_q        (psc_q),
    .per_eff      (per_eff),
    .crst         (crst),
    .en_fall      (en_fall)
  );

  tmr_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (en_q),
    .tick_en (tick_en),
    .restart (wr_ctrl | wr_reload),
    .psc     (psc_q),
    .step    (step)
  );

  tmr_count #(.DATA_W(DATA_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .wr_reload (wr_reload),
    .crst      (crst),
    .en_fall   (en_fall),
    .per_eff   (per_eff),
    .wr_data   (wr_data),
    .count_q   (count_q),
    .reload_q  (reload_q),
    .zero_evt  (zero_evt),
    .step_zero (step_zero)
  );

  tmr_pend u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (zero_evt),
    .clr_req (wr_pend & wr_data[0]),
    .ie      (ie_q),
    .pend_q  (pend_q),
    .irq     (irq)
  );

  always_comb begin
    ctrl_word              = '0;
    ctrl_word[PSC_W-1:0]   = psc_q;
    ctrl_word[BIT_ACT]     = act_q;
    ctrl_word[BIT_PER]     = per_q;
    ctrl_word[BIT_IE]      = ie_q;
    ctrl_word[BIT_EN]      = en_q;
  end

  always_comb begin
    case (rd_sel)
      SEL_CTRL:   rd_data = ctrl_word;
      SEL_RELOAD: rd_data = reload_q;
      SEL_COUNT:  rd_data = count_q;
      default:    rd_data = {{(DATA_W-1){1'b0}}, pend_q};
    endcase
  end
endmodule

// File: rtl/tmr_channel_chk.sv
`timescale 1ns/1ps
module tmr_channel_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic              en_q,
  input logic              per_q,
  input logic              act_q,
  input logic [DATA_W-1:0] count_q,
  input logic [DATA_W-1:0] reload_q,
  input logic              pend_q
);
  import tmr_pkg::*;

  // R3
  active_tracks_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q == en_q);

  // R6
  crst_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_CTRL && wr_data[BIT_RST])
    |=> (!en_q && count_q == $past(reload_q)));

  // R9
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_PEND && wr_data[0] && !en_q) |=> !pend_q);

  // R11
  count_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_COUNT && !en_q) |=> $stable(count_q));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_en) |=> $stable(count_q));

  // R5
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !per_q && !wr_en) |=> (en_q || (pend_q && count_q == '0)));
endmodule

bind tmr_channel tmr_channel_chk #(.DATA_W(DATA_W)) u_tmr_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .wr_data  (wr_data),
  .en_q     (en_q),
  .per_q    (per_q),
  .act_q    (act_q),
  .count_q  (count_q),
  .reload_q (reload_q),
  .pend_q   (pend_q)
);

// File: tb/test_tmr_channel.sv
`timescale 1ns/1ps
module test_tmr_channel;
  logic        clk, rst_n, tick_en, wr_en, irq;
  logic [1:0]  wr_sel, rd_sel;
  logic [31:0] wr_data, rd_data;
  int n_chk, n_bad, wd_cnt;

  // reference model state
  logic        m_en, m_ie, m_per, m_act, m_pend;
  logic [7:0]  m_psc, m_ph;
  logic [31:0] m_cnt, m_rld;

  localparam logic [31:0] EN  = 32'h4000_0000;
  localparam logic [31:0] IE  = 32'h2000_0000;
  localparam logic [31:0] PER = 32'h0800_0000;
  localparam logic [31:0] RST = 32'h0400_0000;
  localparam logic [31:0] JUNK = 32'h91FF_FF00;

  tmr_channel i_tmr_channel (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] exp_ctrl();
    return {1'b0, m_en, m_ie, 1'b0, m_per, 1'b0, m_act, 17'd0, m_psc};
  endfunction

  task automatic model_reset();
    m_en = 0; m_ie = 0; m_per = 0; m_act = 0; m_pend = 0;
    m_psc = 8'd5; m_ph = 0; m_cnt = 0; m_rld = 0;
  endtask

  always @(posedge clk) begin : mdl
    logic cw, rw, pw, crst, nen, step, efall, pereff, zs, zd;
    logic [31:0] nc;
    logic [7:0]  nph;
    if (rst_n) begin
      cw   = wr_en && wr_sel == 2'd0;
      rw   = wr_en && wr_sel == 2'd1;
      pw   = wr_en && wr_sel == 2'd3;
      crst = cw && wr_data[26];
      nen  = wr_data[30] && !wr_data[26];
      step = m_en && tick_en && (m_ph == m_psc) && !cw && !rw;
      efall  = cw && m_en && !nen;
      pereff = cw ? wr_data[27] : m_per;
      zs = step && (m_cnt <= 32'd1);
      zd = efall && ((crst ? m_rld : m_cnt) == 32'd0);
      nc = m_cnt;
      if (crst) nc = m_rld;
      else if (rw) nc = wr_data;
      else if (zs || zd) nc = pereff ? m_rld : 32'd0;
      else if (step) nc = m_cnt - 32'd1;
      nph = m_ph;
      if (cw || rw) nph = 0;
      else if (m_en && tick_en) nph = (m_ph == m_psc) ? 8'd0 : m_ph + 8'd1;
      if (zs || zd) m_pend = 1'b1;
      else if (pw && wr_data[0]) m_pend = 1'b0;
      if (cw) begin
        m_en = nen; m_act = nen; m_ie = wr_data[29];
        m_per = wr_data[27]; m_psc = wr_data[7:0];
      end else if (zs && !m_per) begin
        m_en = 1'b0; m_act = 1'b0;
      end
      if (rw) m_rld = wr_data;
      m_cnt = nc;
      m_ph  = nph;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    for (int s = 0; s < 4; s++) begin
      rd_sel = s[1:0];
      #0.2;
      case (s)
        0: check("R2 R3 R6 control word", rd_data, exp_ctrl());
        1: check("R8 reload value", rd_data, m_rld);
        2: check("R4 R5 R7 R11 count", rd_data, m_cnt);
        default: check("R5 R9 pending flag", rd_data, {31'd0, m_pend});
      endcase
    end
    check("R10 irq", {31'd0, irq}, {31'd0, m_ie & m_pend});
  endtask

  task automatic drive(input logic we, input logic [1:0] sel,
                       input logic [31:0] d, input logic tk);
    compare_all();
    wr_en = we; wr_sel = sel; wr_data = d; tick_en = tk;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 2'd0, 32'd0, 1'b1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    int r;
    n_chk = 0; n_bad = 0; wd_cnt = 0;
    void'($urandom(32'd20240611));
    rst_n = 0; tick_en = 0; wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset values
    rd_sel = 2'd0; #0.2 check("R1 reset control word", rd_data, 32'h0000_0005);
    rd_sel = 2'd1; #0.2 check("R1 reset reload", rd_data, 32'd0);
    rd_sel = 2'd2; #0.2 check("R1 reset count", rd_data, 32'd0);
    rd_sel = 2'd3; #0.2 check("R1 reset pending", rd_data, 32'd0);
    check("R1 reset irq", {31'd0, irq}, 32'd0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R8 reload then R5 one-shot run at prescale 0
    drive(1, 2'd1, 32'd3, 1);
    drive(1, 2'd0, EN, 1);
    idle(6);
    // R9 clear with 1, then 0 has no effect
    drive(1, 2'd3, 32'd1, 1);
    drive(1, 2'd3, 32'd0, 1);
    // R2 reserved and active bits ignored, R4 prescale 1, R5 periodic
    drive(1, 2'd0, EN | IE | PER | JUNK | 32'h0200_0001, 1);
    idle(9);
    // R11 count write while running
    drive(1, 2'd2, 32'h0000_DEAD, 1);
    idle(5);
    // R6 restart together with enable
    drive(1, 2'd0, EN | IE | PER | RST | 32'd1, 1);
    idle(3);
    drive(1, 2'd0, EN | PER | 32'd2, 1);
    idle(4);
    drive(1, 2'd1, 32'd2, 1);           // R8 reload while running
    idle(8);
    drive(1, 2'd0, PER | 32'd2, 1);     // R7 disable holds count
    idle(4);
    drive(1, 2'd1, 32'd0, 1);
    drive(1, 2'd0, EN | PER, 0);
    drive(1, 2'd0, IE | PER, 0);        // R7 disable at count 0 raises zero event
    idle(2);
    // R4 prescale change mid count
    drive(1, 2'd1, 32'd9, 1);
    drive(1, 2'd0, EN | 32'd3, 1);
    idle(6);
    drive(1, 2'd0, EN | 32'd0, 1);
    idle(12);

    // constrained random phase
    for (int c = 0; c < 4000; c++) begin
      r = int'($urandom % 100);
      if (r < 4) begin
        d = 32'($urandom) & (JUNK | 32'h0200_0000);
        if ($urandom % 10 < 7) d |= EN;
        if ($urandom % 2 == 1) d |= IE;
        if ($urandom % 2 == 1) d |= PER;
        if ($urandom % 10 == 0) d |= RST;
        d[7:0] = ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 3);
        drive(1, 2'd0, d, 1'($urandom % 4 != 0));
      end else if (r < 7) begin
        drive(1, 2'd1, 32'($urandom % 12), 1'($urandom % 4 != 0));
      end else if (r < 10) begin
        drive(1, 2'd3, 32'($urandom), 1'($urandom % 4 != 0));
      end else if (r < 12) begin
        drive(1, 2'd2, 32'($urandom), 1'($urandom % 4 != 0));
      end else begin
        drive(0, 2'($urandom), 32'($urandom), 1'($urandom % 4 != 0));
      end
    end
    compare_all();
    finish_run();
  end
endmodule